// File: doc/BRIEF.md
# Dual-Target Level Interrupt Aggregator

This block collects up to 32 active-high, level-sensitive interrupt request lines and fans them out to four outputs: an ordinary interrupt line and a machine-check line for each of two processor cores. Every output has its own enable mask. An output stays high for as long as any input enabled by its mask is high. Nothing is latched and nothing is acknowledged. A request goes away only when its source drops it or when software clears the enable bit. The routing is not exclusive, so one source can raise several outputs at the same moment.

Software reaches the block through a plain 32-bit register port with a write strobe and a combinational read path. Through this port it can:
- read the synchronised input levels;
- read and write the four masks;
- read a priority helper that reports the highest-numbered source that is both pending and enabled for core 0's interrupt line.

A parameter marks which input bits are implemented. The others read as zero and cannot be enabled.

Top module: `lvl_irq_agg`

## Requirements
- R1: The status register at offset 0x00 reads the input levels after a two-flop synchroniser. A change on `irq_in` is visible there two clock edges later. Bits that are not implemented (default: bits 31..17) always read 0.
- R2: The four enable masks sit at these offsets, and each reads back the last value written with unimplemented bits forced to 0:
  - interrupt mask for core 0 at 0x10;
  - interrupt mask for core 1 at 0x14;
  - machine-check mask for core 0 at 0x18;
  - machine-check mask for core 1 at 0x1C.
- R3: Synchronous reset clears all four masks and the synchroniser, and drives all four outputs low.
- R4: Each output is registered. It is high one edge after (status AND its mask) is non-zero, which is three edges after an input change. A mask write reaches the output one edge after the write edge.
- R5: The outputs follow levels. An output falls once its enabled inputs drop, or once the enabling mask bits are cleared, with no acknowledge step.
- R6: The four outputs are computed independently. A single input enabled in several masks raises all of those outputs together.
- R7: The read-only register at 0x20 returns {valid, index} in bits [5:0]. Bit 5 is valid, and bits 4:0 give the highest set bit of (status AND core-0 interrupt mask). The register reads 0 when no such bit is set.
- R8: Writes to 0x00, to 0x20 and to unmapped or unaligned offsets change no mask. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Asynchronous level interrupt requests |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| int_out | output | 2 | Interrupt line per core |
| mchk_out | output | 2 | Machine-check line per core |

## Verification
The hardest case to reach from the ports is one source raising several outputs at once while other pending sources stay hidden behind differing masks. This case tests both the independence of the four routes and the priority helper, which must ignore requests enabled only for other targets. A table of vectors programs all four masks to overlapping and disjoint patterns against a fixed input pattern, including bits in the unimplemented range, before it checks every output together with the helper register. Directed steps then walk an input change edge by edge through the synchroniser and the output register.

// File: rtl/agg_pkg.sv
`timescale 1ns/1ps
package agg_pkg;

    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int N_TGT   = 4;   // order: int core0, int core1, mchk core0, mchk core1

    localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_INT0   = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_INT1   = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_MC0    = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_MC1    = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_INDEX  = 8'h20;

    typedef enum logic [2:0] {
        SEL_STATUS,
        SEL_INT0,
        SEL_INT1,
        SEL_MC0,
        SEL_MC1,
        SEL_INDEX,
        SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_STATUS: return SEL_STATUS;
            OFS_INT0:   return SEL_INT0;
            OFS_INT1:   return SEL_INT1;
            OFS_MC0:    return SEL_MC0;
            OFS_MC1:    return SEL_MC1;
            OFS_INDEX:  return SEL_INDEX;
            default:    return SEL_NONE;
        endcase
    endfunction

    // Mask slot addressed by a selector, or -1 when it is not a mask.
    function automatic int mask_slot(input reg_sel_e s);
        case (s)
            SEL_INT0: return 0;
            SEL_INT1: return 1;
            SEL_MC0:  return 2;
            SEL_MC1:  return 3;
            default:  return -1;
        endcase
    endfunction

endpackage

// File: rtl/agg_sync.sv
`timescale 1ns/1ps
module agg_sync #(
    parameter int N      = 32,
    parameter int STAGES = 2,
    parameter logic [N-1:0] IMPL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= '0;
                    else     chain[0] <= d & IMPL;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/agg_regs.sv
`timescale 1ns/1ps
module agg_regs
    import agg_pkg::*;
#(
    parameter int N = 32,
    parameter logic [N-1:0] IMPL = '1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr,
    input  reg_sel_e                 sel,
    input  logic [DATA_W-1:0]        wdata,
    output logic [N_TGT-1:0][N-1:0]  masks
);
    generate
        for (genvar t = 0; t < N_TGT; t++) begin : g_mask
            always_ff @(posedge clk) begin
                if (rst)
                    masks[t] <= '0;
                else if (wr && mask_slot(sel) == t)
                    masks[t] <= wdata[N-1:0] & IMPL;
            end

            AST_MASK_WRITE: assert property (@(posedge clk) disable iff (rst)
                (wr && mask_slot(sel) == t) |=> (masks[t] == ($past(wdata[N-1:0]) & IMPL)))
                else $error("mask write not stored"); // R2
        end
    endgenerate

    AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr && mask_slot(sel) < 0) |=> $stable(masks))
        else $error("non-mask write changed a mask"); // R8

    AST_MASK_CLEARED: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (masks == '0))
        else $error("mask not cleared by reset"); // R3

endmodule

// File: rtl/agg_prio.sv
`timescale 1ns/1ps
module agg_prio #(
    parameter int N  = 32,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  vec,
    output logic          valid,
    output logic [IW-1:0] idx
);
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (vec[i]) begin
                valid = 1'b1;
                idx   = IW'(i);
            end
        end
    end

    AST_INDEX_SET: assert property (@(posedge clk) disable iff (rst)
        valid |-> vec[idx])
        else $error("reported index not pending"); // R7

    AST_INDEX_TOP: assert property (@(posedge clk) disable iff (rst)
        valid |-> ((vec >> idx) == N'(1)))
        else $error("higher pending bit skipped"); // R7

    AST_INDEX_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (vec == '0) |-> (!valid && idx == '0))
        else $error("index reported with nothing pending"); // R7

endmodule

// File: rtl/agg_route.sv
`timescale 1ns/1ps
module agg_route
    import agg_pkg::*;
#(
    parameter int N = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N-1:0]             status,
    input  logic [N_TGT-1:0][N-1:0]  masks,
    output logic [N_TGT-1:0]         lines
);
    generate
        for (genvar t = 0; t < N_TGT; t++) begin : g_tgt
            always_ff @(posedge clk) begin
                if (rst) lines[t] <= 1'b0;
                else     lines[t] <= |(status & masks[t]);
            end

            AST_LINE_TRACKS: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> (lines[t] == ($past(status & masks[t]) != '0)))
                else $error("output does not follow enabled level"); // R4
        end
    endgenerate

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (lines == '0))
        else $error("output high after reset"); // R3

endmodule

// File: rtl/lvl_irq_agg.sv
`timescale 1ns/1ps
module lvl_irq_agg
    import agg_pkg::*;
#(
    parameter int N_SRC = 32,
    parameter logic [N_SRC-1:0] SRC_IMPL = 32'h0001_FFFF,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  irq_in,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [1:0]        int_out,
    output logic [1:0]        mchk_out
);
    localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    logic [N_SRC-1:0]            status;
    logic [N_TGT-1:0][N_SRC-1:0] masks;
    logic [N_TGT-1:0]            lines;
    logic                        top_valid;
    logic [IW-1:0]               top_idx;
    reg_sel_e                    sel;

    assign sel = decode_sel(reg_addr);

    agg_sync #(.N(N_SRC), .STAGES(SYNC_STAGES), .IMPL(SRC_IMPL)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (irq_in),
        .q   (status)
    );

    agg_regs #(.N(N_SRC), .IMPL(SRC_IMPL)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (reg_wr),
        .sel   (sel),
        .wdata (reg_wdata),
        .masks (masks)
    );

    agg_prio #(.N(N_SRC), .IW(IW)) u_prio (
        .clk   (clk),
        .rst   (rst),
        .vec   (status & masks[0]),
        .valid (top_valid),
        .idx   (top_idx)
    );

    agg_route #(.N(N_SRC)) u_route (
        .clk    (clk),
        .rst    (rst),
        .status (status),
        .masks  (masks),
        .lines  (lines)
    );

    assign int_out  = lines[1:0];
    assign mchk_out = lines[3:2];

    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_STATUS: reg_rdata[N_SRC-1:0] = status;
            SEL_INT0:   reg_rdata[N_SRC-1:0] = masks[0];
            SEL_INT1:   reg_rdata[N_SRC-1:0] = masks[1];
            SEL_MC0:    reg_rdata[N_SRC-1:0] = masks[2];
            SEL_MC1:    reg_rdata[N_SRC-1:0] = masks[3];
            SEL_INDEX:  reg_rdata[IW:0]      = {top_valid, top_idx};
            default:    reg_rdata = '0;
        endcase
    end

    AST_STATUS_RSVD: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_STATUS) |-> ((reg_rdata[N_SRC-1:0] & ~SRC_IMPL) == '0))
        else $error("unimplemented status bit set"); // R1

    AST_STATUS_LAG: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst, 2) && !$past(rst)) |-> (status == ($past(irq_in, 2) & SRC_IMPL)))
        else $error("status not two edges behind input"); // R1

    AST_SHARED_SOURCE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(status & masks[0] & masks[2]) != '0)) |-> (int_out[0] && mchk_out[0]))
        else $error("shared source did not raise both lines"); // R6

endmodule

// File: tb/sim_lvl_irq_agg.sv
`timescale 1ns/1ps
module sim_lvl_irq_agg;
    localparam logic [31:0] IMPL = 32'h0001_FFFF;
    localparam int NV = 8;

    // stimulus: inputs, masks int0/int1/mc0/mc1; expected {mc1,mc0,int1,int0} and index reg
    localparam logic [31:0] V_IRQ [NV] = '{32'h0000_0001, 32'h0001_0000, 32'h8000_0001, 32'h0000_F0F0,
                                           32'h0000_F0F0, 32'h0000_0024, 32'h0000_0000, 32'h0001_FFFF};
    localparam logic [31:0] V_M0  [NV] = '{32'h0000_0001, 32'hFFFF_FFFF, 32'h8000_0000, 32'h0000_0F00,
                                           32'h0000_FFFF, 32'h0000_0024, 32'hFFFF_FFFF, 32'h0000_0100};
    localparam logic [31:0] V_M1  [NV] = '{32'h0, 32'h0001_0000, 32'h0000_0001, 32'h0000_00F0,
                                           32'h0, 32'h0000_0024, 32'hFFFF_FFFF, 32'h0};
    localparam logic [31:0] V_C0  [NV] = '{32'h0, 32'h0, 32'h0000_0001, 32'h0,
                                           32'h0000_F0F0, 32'h0000_0024, 32'hFFFF_FFFF, 32'h0};
    localparam logic [31:0] V_C1  [NV] = '{32'h0, 32'h0001_0000, 32'h0, 32'h0000_F000,
                                           32'h0, 32'h0000_0024, 32'hFFFF_FFFF, 32'h0000_0001};
    localparam logic [3:0]  V_OUT [NV] = '{4'b0001, 4'b1011, 4'b0110, 4'b1010,
                                           4'b0101, 4'b1111, 4'b0000, 4'b1001};
    localparam logic [31:0] V_IDX [NV] = '{32'h20, 32'h30, 32'h00, 32'h00,
                                           32'h2F, 32'h25, 32'h00, 32'h28};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] irq_in = '0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  int_out;
    logic [1:0]  mchk_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lvl_irq_agg u0 (
        .clk       (clk),
        .rst       (rst),
        .irq_in    (irq_in),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .int_out   (int_out),
        .mchk_out  (mchk_out)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #2;
        d = reg_rdata;
    endtask

    function automatic logic [31:0] outs();
        return {28'b0, mchk_out, int_out};
    endfunction

    initial begin
        logic [31:0] v;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R3: reset state
        chk("R3 outputs", outs(), 32'h0);
        rd(8'h10, v); chk("R3 int0 mask", v, 32'h0);
        rd(8'h14, v); chk("R3 int1 mask", v, 32'h0);
        rd(8'h18, v); chk("R3 mc0 mask", v, 32'h0);
        rd(8'h1C, v); chk("R3 mc1 mask", v, 32'h0);
        rd(8'h20, v); chk("R7 index empty", v, 32'h0);

        // vector table: R2 R4 R6 R7 R1
        for (int k = 0; k < NV; k++) begin
            wr(8'h10, V_M0[k]);
            wr(8'h14, V_M1[k]);
            wr(8'h18, V_C0[k]);
            wr(8'h1C, V_C1[k]);
            @(negedge clk);
            irq_in = V_IRQ[k];
            repeat (3) @(negedge clk);
            chk("R4 R6 outputs", outs(), {28'b0, V_OUT[k]});
            rd(8'h20, v); chk("R7 index", v, V_IDX[k]);
            rd(8'h00, v); chk("R1 status", v, V_IRQ[k] & IMPL);
            rd(8'h10, v); chk("R2 int0 readback", v, V_M0[k] & IMPL);
            rd(8'h1C, v); chk("R2 mc1 readback", v, V_C1[k] & IMPL);
        end

        // R1 R4: edge-by-edge latency
        wr(8'h10, 32'h0000_0008);
        wr(8'h14, 32'h0);
        wr(8'h18, 32'h0);
        wr(8'h1C, 32'h0);
        @(negedge clk); irq_in = 32'h0;
        repeat (4) @(negedge clk);
        chk("R4 idle", outs(), 32'h0);
        irq_in = 32'h0000_0008;
        @(negedge clk);
        rd(8'h00, v); chk("R1 status after one edge", v, 32'h0);
        @(negedge clk);
        rd(8'h00, v); chk("R1 status after two edges", v, 32'h8);
        chk("R4 output after two edges", outs(), 32'h0);
        @(negedge clk);
        chk("R4 output after three edges", outs(), 32'h1);

        // R5: drop the level
        irq_in = 32'h0;
        repeat (2) @(negedge clk);
        chk("R5 still high before drop reaches output", outs(), 32'h1);
        @(negedge clk);
        chk("R5 falls after input drops", outs(), 32'h0);

        // R5: clear the mask with the input still high
        irq_in = 32'h0000_0008;
        repeat (3) @(negedge clk);
        chk("R5 high again", outs(), 32'h1);
        wr(8'h10, 32'h0);   // write edge passed; output updates on the next edge
        chk("R4 mask write one edge later", outs(), 32'h1);
        @(negedge clk);
        chk("R5 falls after mask cleared", outs(), 32'h0);

        // R8: writes that must not land anywhere
        wr(8'h10, 32'h0000_00FF);
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h11, 32'hFFFF_FFFF);
        wr(8'h24, 32'hFFFF_FFFF);
        rd(8'h10, v); chk("R8 int0 mask untouched", v, 32'h0000_00FF);
        rd(8'h14, v); chk("R8 int1 mask untouched", v, 32'h0);
        rd(8'h18, v); chk("R8 mc0 mask untouched", v, 32'h0);
        rd(8'h00, v); chk("R8 status not written", v, 32'h8);
        rd(8'h04, v); chk("R8 unmapped read", v, 32'h0);
        rd(8'h24, v); chk("R8 unmapped read high", v, 32'h0);
        rd(8'h11, v); chk("R8 unaligned read", v, 32'h0);

        // R3: reset during activity
        wr(8'h1C, 32'h0000_0008);
        repeat (2) @(negedge clk);
        chk("R6 before reset", outs(), 32'h9);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #2;
        chk("R3 outputs after reset", outs(), 32'h0);
        rd(8'h10, v); chk("R3 int0 cleared", v, 32'h0);
        rd(8'h1C, v); chk("R3 mc1 cleared", v, 32'h0);
        rd(8'h00, v); chk("R3 status cleared", v, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule